// File: doc/BRIEF.md
# Byte-to-word stream packer

This block takes a stream of single bytes on a valid/ready port and packs them into 32-bit words on a second valid/ready port. It fills byte lanes from the least significant lane upward in arrival order. A word goes out when all four lanes hold data. It also goes out early when a byte flagged as end-of-packet arrives. A keep mask marks which lanes carry data, and an output flag marks the word holding the packet's last byte.

There is a single output register. Back-pressure works as follows. The byte port is ready when no word is waiting, or when the waiting word is being taken in the same cycle. While the word port is stalled, the presented word, mask and flag stay unchanged, and no byte is taken. Without stalls, the block accepts one byte per cycle.

Top module: `byte_word_packer`

## Requirements
- R1: A byte is taken on a rising edge only when `in_valid` and `in_ready` are both high, and a word is handed off only when `out_valid` and `out_ready` are both high; while a word waits and `out_ready` is low, `in_ready` is low.
- R2: The bytes of one word occupy lanes in arrival order: the first in bits [7:0], the second in [15:8], the third in [23:16], the fourth in [31:24].
- R3: Once four bytes have been taken, `out_valid` is high from the next cycle on, with `out_keep` = 4'b1111.
- R4: When a byte with `in_last` high is taken as the first, second or third byte of a word, the partial word is valid in the cycle right after that edge, with no flush cycle.
- R5: Lanes of a partial word that hold no byte read as zero.
- R6: `out_keep` is 4'b0001, 4'b0011, 4'b0111 or 4'b1111 for one, two, three or four valid bytes.
- R7: `out_last` is high exactly on the word that holds a byte taken with `in_last` high, including a full word whose fourth byte was the last one.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_keep`, `out_last` and `out_valid` hold their values.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high, so the block takes one byte every cycle when the output never stalls.
- R10: A synchronous active-high `rst` clears `out_valid` and discards any partly collected bytes, so the next byte lands in lane 0.
- R11: After a word is emitted, the next byte taken goes to lane 0 and the earlier contents do not show in the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Incoming byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_last | input | 1 | Incoming byte ends its packet |
| out_data | output | 32 | Packed word |
| out_keep | output | 4 | Lane-valid mask, thermometer from lane 0 |
| out_valid | output | 1 | Packed word is valid |
| out_ready | input | 1 | Receiver takes the word this cycle |
| out_last | output | 1 | Word holds the packet's final byte |

## Verification
The most important overlap is a word being emitted and a byte being taken in the same cycle. When `out_ready` is high while a word is pending, the next byte must go to the proper lane. If that byte completes or ends a word, the new word must replace the old one with no gap. The bench provokes this with back-to-back bytes and short packets while `out_ready` is held high. It also randomises input gaps and output stalls. On every clock, a behavioural model judges the ready signal and the whole output word. A second overlap is an early end-of-packet arriving just as a stall releases, which the random phase also hits.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
  localparam int BWP_LANE_W = 8;
  localparam int BWP_LANES  = 4;

  // thermometer mask with the n lowest bits set
  function automatic logic [63:0] fill_mask(input int unsigned n);
    logic [63:0] m;
    m = '0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/bwp_lane_ctr.sv
module bwp_lane_ctr #(
  parameter int LANES = 4,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          clear,
  output logic [CW-1:0] lane,
  output logic          at_top
);
  logic [CW-1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      lane_q <= '0;
    end else if (step) begin
      lane_q <= lane_q + 1'b1;
    end
  end

  assign lane   = lane_q;
  assign at_top = (lane_q == CW'(LANES - 1));
endmodule

// File: rtl/bwp_lane_acc.sv
module bwp_lane_acc #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WW = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              flush,
  input  logic [CW-1:0]     sel,
  input  logic [LANE_W-1:0] byte_in,
  output logic [WW-1:0]     merged
);
  logic [WW-1:0] acc_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (take && (sel == CW'(g))) begin
        merged[g*LANE_W +: LANE_W] = byte_in;
      end else begin
        merged[g*LANE_W +: LANE_W] = acc_q[g*LANE_W +: LANE_W];
      end
    end
  end

  // cleared after every emitted word so unused lanes read as zero
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc_q <= '0;
    end else if (take) begin
      acc_q <= merged;
    end
  end
endmodule

// File: rtl/bwp_out_reg.sv
module bwp_out_reg #(
  parameter int WW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WW-1:0]    ld_data,
  input  logic [LANES-1:0] ld_keep,
  input  logic             ld_last,
  input  logic             drain,
  output logic             valid,
  output logic [WW-1:0]    data,
  output logic [LANES-1:0] keep,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      keep  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ld_data;
      keep  <= ld_keep;
      last  <= ld_last;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
  import bwp_pkg::*;
#(
  parameter int LANE_W = BWP_LANE_W,
  parameter int LANES  = BWP_LANES,
  localparam int CW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WW = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  output logic [WW-1:0]     out_data,
  output logic [LANES-1:0]  out_keep,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last
);
  logic              accept;
  logic              emit;
  logic [CW-1:0]     lane;
  logic              at_top;
  logic [WW-1:0]     merged;
  logic [LANES-1:0]  new_keep;
  logic              drain;

  assign drain    = out_valid && out_ready;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign emit     = accept && (at_top || in_last);

  always_comb begin
    new_keep = LANES'(fill_mask(32'(lane) + 32'd1));
  end

  bwp_lane_ctr #(.LANES(LANES)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .step   (accept),
    .clear  (emit),
    .lane   (lane),
    .at_top (at_top)
  );

  bwp_lane_acc #(.LANE_W(LANE_W), .LANES(LANES)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .take    (accept),
    .flush   (emit),
    .sel     (lane),
    .byte_in (in_data),
    .merged  (merged)
  );

  bwp_out_reg #(.WW(WW), .LANES(LANES)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (emit),
    .ld_data (merged),
    .ld_keep (new_keep),
    .ld_last (in_last),
    .drain   (drain),
    .valid   (out_valid),
    .data    (out_data),
    .keep    (out_keep),
    .last    (out_last)
  );
endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int WW = LANE_W * LANES
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_last,
  input logic [WW-1:0]     out_data,
  input logic [LANES-1:0]  out_keep,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last
);
  logic [WW-1:0] lane_mask;
  logic          keep_thermo;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{out_keep[g]}};
  end

  always_comb begin
    keep_thermo = 1'b0;
    for (int n = 1; n <= LANES; n++) begin
      if (out_keep == LANES'((64'd1 << n) - 64'd1)) keep_thermo = 1'b1;
    end
  end

  p_stall_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_full_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_keep == {LANES{1'b1}}));

  p_early_last_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> (out_valid && out_last));

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_data & ~lane_mask) == '0));

  p_thermo_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> keep_thermo);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)));

  p_reset_r10: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind byte_word_packer bwp_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_data  (out_data),
  .out_keep  (out_keep),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last)
);

// File: tb/byte_word_packer_test.sv
`timescale 1ns/1ps
module byte_word_packer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_last = 1'b0;
  logic [31:0] out_data;
  logic [3:0]  out_keep;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  byte_word_packer uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .out_data(out_data),
    .out_keep(out_keep), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last)
  );

  // behavioural reference: list of collected bytes plus one pending word
  byte unsigned pend[$];
  bit          m_valid = 1'b0;
  logic [31:0] m_data  = '0;
  logic [3:0]  m_keep  = '0;
  bit          m_last  = 1'b0;

  always @(posedge clk) begin
    bit take;
    if (rst) begin
      pend.delete();
      m_valid = 1'b0;
      m_data = '0; m_keep = '0; m_last = 1'b0;
    end else begin
      take = in_valid && (!m_valid || out_ready);
      if (m_valid && out_ready) m_valid = 1'b0;
      if (take) begin
        pend.push_back(in_data);
        if (pend.size() == 4 || in_last) begin
          m_data = '0;
          m_keep = '0;
          foreach (pend[k]) begin
            m_data[k*8 +: 8] = pend[k];
            m_keep[k] = 1'b1;
          end
          m_last  = in_last;
          m_valid = 1'b1;
          pend.delete();
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every port against the model; called at the falling edge
  task automatic compare_all();
    check(out_valid == m_valid, "R3/R4 valid", 32'(out_valid), 32'(m_valid));
    check(in_ready == (!m_valid || out_ready), "R9 in_ready", 32'(in_ready),
          32'(!m_valid || out_ready));
    if (m_valid) begin
      check(out_data == m_data, "R2/R5 data", out_data, m_data);
      check(out_keep == m_keep, "R6 keep", 32'(out_keep), 32'(m_keep));
      check(out_last == m_last, "R7 last", 32'(out_last), 32'(m_last));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic put(input logic [7:0] d, input bit l);
    in_valid = 1'b1; in_data = d; in_last = l; out_ready = 1'b1;
    tick();
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    tick(); tick();
    check(out_valid == 1'b0, "R10 reset valid", 32'(out_valid), 32'd0);
    rst = 1'b0;

    // full word, no last (R2, R3)
    put(8'h11, 0); put(8'h22, 0); put(8'h33, 0); put(8'h44, 0);
    check(out_valid && out_data == 32'h44332211, "R2 lane order", out_data, 32'h44332211);
    check(out_keep == 4'b1111, "R3 full keep", 32'(out_keep), 32'hf);

    // one-byte packet: valid right after the edge (R4, R5, R6, R11)
    put(8'hA5, 1);
    check(out_valid && out_keep == 4'b0001, "R4 early last", 32'(out_keep), 32'h1);
    check(out_data == 32'h000000A5, "R11 lane0 restart", out_data, 32'h000000A5);
    put(8'h01, 0); put(8'h02, 1);
    check(out_data == 32'h00000201 && out_keep == 4'b0011, "R5 zero fill 2", out_data,
          32'h00000201);
    put(8'h0A, 0); put(8'h0B, 0); put(8'h0C, 1);
    check(out_keep == 4'b0111 && out_last, "R6 keep 3", 32'(out_keep), 32'h7);
    // last on fourth byte (R7)
    put(8'hF1, 0); put(8'hF2, 0); put(8'hF3, 0); put(8'hF4, 1);
    check(out_last == 1'b1 && out_keep == 4'hf, "R7 full last", 32'(out_last), 32'd1);

    // stall: word held, input blocked (R1, R8)
    put(8'h55, 1);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h66; in_last = 1'b1;
    tick(); tick();
    check(in_ready == 1'b0, "R1 backpressure", 32'(in_ready), 32'd0);
    check(out_data == 32'h00000055, "R8 hold", out_data, 32'h00000055);
    out_ready = 1'b1;
    tick();
    check(out_data == 32'h00000066, "R1 take after release", out_data, 32'h00000066);
    in_valid = 1'b0; in_last = 1'b0;
    tick();

    // reset in the middle of a packet (R10)
    put(8'h77, 0); put(8'h88, 0);
    rst = 1'b1; tick(); rst = 1'b0;
    put(8'h99, 1);
    check(out_data == 32'h00000099 && out_keep == 4'b0001, "R10 discard partial",
          out_data, 32'h00000099);

    // random traffic with gaps and stalls
    for (int i = 0; i < 4000; i++) begin
      in_valid  = ($urandom_range(0, 3) != 0);
      in_data   = 8'($urandom);
      in_last   = ($urandom_range(0, 4) == 0);
      out_ready = ($urandom_range(0, 2) != 0);
      tick();
    end
    // sustained throughput with no stalls (R9)
    for (int i = 0; i < 200; i++) begin
      in_valid = 1'b1; in_data = 8'(i); in_last = ($urandom_range(0, 6) == 0);
      out_ready = 1'b1;
      tick();
      check(in_ready == 1'b1, "R9 full rate", 32'(in_ready), 32'd1);
    end
    in_valid = 1'b0;
    tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule